// File: doc/BRIEF.md
# Quadrature Encoder Count-Pulse Converter

This block takes the two phase signals of an optical or magnetic position encoder and turns them into count pulses for an up/down counter. Each phase first goes through a two-flop synchronizer and a debounce stage. A new level reaches the decoder only after it has held for a set number of system clocks, so encoder dither is removed before any decoding happens. The decoder compares the previous debounced phase pair with the current one. It works out the direction of motion and raises a count event for each valid step, or for one step per full cycle when coarse resolution is chosen.

Each count event becomes an active-low pulse. The pulse width in system clocks comes from an input port. A build-time parameter selects one of two output styles. The first drives two separate pulse trains, one for up counts and one for down counts. The second drives one clock that carries every count plus a direction level, which a counter samples on the rising edge of that clock. If an event arrives while a pulse is still running, the event is held in a one-entry slot and sent once the output has returned high.

Top module: `quad_pulse_conv`

## Requirements
- R1: A change on either phase input reaches the decoder only after it has been seen for FILT_LEN consecutive clocks behind the two-flop synchronizer. A glitch shorter than that causes no pulse.
- R2: When `res_x4` is high, every valid single-phase step, forward or backward, produces exactly one pulse.
- R3: When `res_x4` is low, an up pulse is produced only when A rises while B is low. A down pulse is produced only when A falls while B is low. No other step produces a pulse, so stepping back at that position counts back.
- R4: With the state written as {B,A}, the forward sequence is 00, 01, 11, 10 (A leads) and means up; the reverse sequence means down. In separate style, up pulses appear on `cnt_clk_n` and down pulses on `cnt_aux`, and the two are never low together.
- R5: After reset both pulse outputs are high in separate style, the combined clock is high, and `step_err` is 0.
- R6: Each pulse holds its output low for `pulse_width` clocks. A value of 0 is treated as 1.
- R7: An event that arrives while a pulse is active is held in a one-entry slot. It is sent after the output has been high for at least one clock. An event that arrives while the slot is already full is discarded.
- R8: A step in which both debounced phases change in the same clock produces no pulse and sets `step_err`. The flag stays set until reset.
- R9: In combined style, `cnt_clk_n` carries every count and `cnt_aux` is high for up and low for down. `cnt_aux` takes its new value on the falling edge of the clock and holds it through the rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enc_a | input | 1 | Encoder phase A, asynchronous |
| enc_b | input | 1 | Encoder phase B, asynchronous |
| res_x4 | input | 1 | High selects x4 resolution, low selects x1 |
| pulse_width | input | PW_W | Pulse low time in clocks (0 treated as 1) |
| cnt_clk_n | output | 1 | Up pulses (separate style) or combined count clock |
| cnt_aux | output | 1 | Down pulses (separate style) or direction level (combined style) |
| step_err | output | 1 | Sticky flag for a step where both phases changed at once |

## Verification
The bench drives a separate-style and a combined-style instance with the same stimulus. It steps through the quadrature cycle in both directions at both resolutions, including a reversal at the x1 counting position. A decoder with the wrong polarity there would count twice in one direction. Short dither bursts check that a filter passing glitches would produce extra pulses. Three events packed into one long pulse check that a missing slot loses the second count and an over-deep slot emits the third. A simultaneous change of both phases checks that the step is rejected and the error flag latches. In combined style, the direction is checked at every rising clock edge, which is where a downstream counter would sample it.

// File: rtl/quad_pulse_conv.sv
module quad_pulse_conv #(
  parameter int FILT_LEN = 4,
  parameter int PW_W     = 8,
  parameter bit COMBINED = 1'b0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            enc_a,
  input  logic            enc_b,
  input  logic            res_x4,
  input  logic [PW_W-1:0] pulse_width,
  output logic            cnt_clk_n,
  output logic            cnt_aux,
  output logic            step_err
);
  localparam int CW = $clog2(FILT_LEN + 1);

  logic [1:0]    s1, s2, flt, prv;
  logic [CW-1:0] fc [2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1  <= '0;
      s2  <= '0;
      flt <= '0;
      prv <= '0;
      fc[0] <= '0;
      fc[1] <= '0;
    end else begin
      s1  <= {enc_b, enc_a};
      s2  <= s1;
      prv <= flt;
      for (int i = 0; i < 2; i++) begin
        if (s2[i] == flt[i]) fc[i] <= '0;
        else if (fc[i] == CW'(FILT_LEN - 1)) begin
          flt[i] <= s2[i];
          fc[i]  <= '0;
        end else fc[i] <= fc[i] + 1'b1;
      end
    end
  end

  wire dbl     = (flt ^ prv) == 2'b11;
  wire step_up = (prv == 2'b00 && flt == 2'b01) || (prv == 2'b01 && flt == 2'b11) ||
                 (prv == 2'b11 && flt == 2'b10) || (prv == 2'b10 && flt == 2'b00);
  wire step_dn = (prv == 2'b01 && flt == 2'b00) || (prv == 2'b11 && flt == 2'b01) ||
                 (prv == 2'b10 && flt == 2'b11) || (prv == 2'b00 && flt == 2'b10);
  wire ev_up   = res_x4 ? step_up : (prv == 2'b00 && flt == 2'b01);
  wire ev_dn   = res_x4 ? step_dn : (prv == 2'b01 && flt == 2'b00);
  wire ev      = ev_up | ev_dn;

  logic [PW_W-1:0] pcnt;
  logic            dir_q, pend_v, pend_dir;
  wire             busy  = |pcnt;
  wire             start = !busy && (pend_v || ev);
  wire [PW_W-1:0]  pw_eff = (pulse_width == '0) ? PW_W'(1) : pulse_width;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt     <= '0;
      dir_q    <= 1'b1;
      pend_v   <= 1'b0;
      pend_dir <= 1'b0;
      step_err <= 1'b0;
    end else begin
      if (dbl) step_err <= 1'b1;
      if (start) begin
        pcnt     <= pw_eff;
        dir_q    <= pend_v ? pend_dir : ev_up;
        pend_v   <= pend_v && ev;
        pend_dir <= ev_up;
      end else begin
        if (busy) pcnt <= pcnt - 1'b1;
        if (ev && !pend_v) begin
          pend_v   <= 1'b1;
          pend_dir <= ev_up;
        end
      end
    end
  end

  generate
    if (COMBINED) begin : g_comb
      assign cnt_clk_n = !busy;
      assign cnt_aux   = dir_q;
      AST_DIR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(cnt_aux)); // R9
    end else begin : g_sep
      assign cnt_clk_n = !(busy && dir_q);
      assign cnt_aux   = !(busy && !dir_q);
      AST_ONE_TRAIN: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({!cnt_clk_n, !cnt_aux})); // R4
    end
  endgenerate

  AST_FILT_A: assert property (@(posedge clk) disable iff (!rst_n)
    (flt[0] != $past(flt[0])) |-> ($past(s2[0]) == flt[0])); // R1
  AST_FILT_B: assert property (@(posedge clk) disable iff (!rst_n)
    (flt[1] != $past(flt[1])) |-> ($past(s2[1]) == flt[1])); // R1
  AST_DBL_NO_EV: assert property (@(posedge clk) disable iff (!rst_n)
    dbl |-> !ev); // R8
  AST_DBL_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    dbl |=> step_err); // R8
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    step_err |=> step_err); // R8
endmodule

// File: tb/quad_pulse_conv_bench.sv
module quad_pulse_conv_bench;
  localparam int PW_W = 8;
  logic clk = 0, rst_n = 0, enc_a = 0, enc_b = 0, res_x4 = 1;
  logic [PW_W-1:0] pulse_width = 8'd3;
  logic s_clk_n, s_aux, s_err, c_clk_n, c_aux, c_err;
  int total = 0, bad = 0, exp_pw = 3, pos = 0;
  bit qs[$], qc[$];
  bit done = 0;

  always #2 clk = ~clk;

  quad_pulse_conv #(.FILT_LEN(4), .PW_W(PW_W), .COMBINED(1'b0)) u_quad_pulse_conv (
    .clk(clk), .rst_n(rst_n), .enc_a(enc_a), .enc_b(enc_b), .res_x4(res_x4),
    .pulse_width(pulse_width), .cnt_clk_n(s_clk_n), .cnt_aux(s_aux), .step_err(s_err));
  quad_pulse_conv #(.FILT_LEN(4), .PW_W(PW_W), .COMBINED(1'b1)) u_quad_pulse_conv_comb (
    .clk(clk), .rst_n(rst_n), .enc_a(enc_a), .enc_b(enc_b), .res_x4(res_x4),
    .pulse_width(pulse_width), .cnt_clk_n(c_clk_n), .cnt_aux(c_aux), .step_err(c_err));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [1:0] gray(input int p);
    case (p & 3) 0: return 2'b00; 1: return 2'b01; 2: return 2'b11; default: return 2'b10; endcase
  endfunction

  task automatic push(input bit d);
    qs.push_back(d);
    qc.push_back(d);
  endtask

  task automatic step(input int d, input bit no_push, input int gap);
    int old = pos;
    pos = (pos + d) & 3;
    {enc_b, enc_a} = gray(pos);
    if (!no_push) begin
      if (res_x4) push(d > 0);
      else if (old == 0 && pos == 1) push(1'b1);
      else if (old == 1 && pos == 0) push(1'b0);
    end
    repeat (gap) @(negedge clk);
  endtask

  bit pu = 1, pd = 1, pc = 1, sdir = 0, cdir = 0;
  int wu = 0, wd = 0, wc = 0;
  always @(negedge clk) if (rst_n) begin
    if (!s_clk_n && !s_aux) chk(0, "R4 both trains low", 1, 0);
    if (pu && !s_clk_n) begin
      if (qs.size() == 0) chk(0, "R2/R3 unexpected up pulse", 1, 0);
      else begin sdir = qs.pop_front(); chk(sdir == 1, "R4 up pulse direction", 1, sdir); end
      wu = 1;
    end else if (!s_clk_n) wu++;
    else if (!pu) chk(wu == exp_pw, "R6 up pulse width", wu, exp_pw);
    if (pd && !s_aux) begin
      if (qs.size() == 0) chk(0, "R2/R3 unexpected down pulse", 1, 0);
      else begin sdir = qs.pop_front(); chk(sdir == 0, "R4 down pulse direction", 0, sdir); end
      wd = 1;
    end else if (!s_aux) wd++;
    else if (!pd) chk(wd == exp_pw, "R6 down pulse width", wd, exp_pw);
    if (pc && !c_clk_n) begin
      if (qc.size() == 0) begin chk(0, "R9 unexpected combined pulse", 1, 0); cdir = c_aux; end
      else cdir = qc.pop_front();
      chk(c_aux == cdir, "R9 direction at falling edge", c_aux, cdir);
      wc = 1;
    end else if (!c_clk_n) wc++;
    else if (!pc) begin
      chk(wc == exp_pw, "R6 combined pulse width", wc, exp_pw);
      chk(c_aux == cdir, "R9 direction at rising edge", c_aux, cdir);
    end
    pu = s_clk_n; pd = s_aux; pc = c_clk_n;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(s_clk_n && s_aux && c_clk_n && !s_err && !c_err, "R5 reset state", {s_clk_n, s_aux, c_clk_n}, 7);
    rst_n = 1;
    repeat (5) @(negedge clk);
    chk(s_clk_n && s_aux && c_clk_n, "R5 idle after reset", {s_clk_n, s_aux, c_clk_n}, 7);
    // R2 x4 forward and backward
    for (int i = 0; i < 8; i++) step(1, 0, 30);
    for (int i = 0; i < 8; i++) step(-1, 0, 30);
    // R3 x1 with reversal at counting position
    res_x4 = 0;
    for (int i = 0; i < 8; i++) step(1, 0, 30);
    step(1, 0, 30); step(-1, 0, 30); step(1, 0, 30); step(-1, 0, 30);
    for (int i = 0; i < 8; i++) step(-1, 0, 30);
    res_x4 = 1;
    // R6 width 1, 0 treated as 1, and 5
    pulse_width = 8'd1; exp_pw = 1; step(1, 0, 30); step(1, 0, 30);
    pulse_width = 8'd0; exp_pw = 1; step(-1, 0, 30); step(-1, 0, 30);
    pulse_width = 8'd5; exp_pw = 5; step(1, 0, 30); step(-1, 0, 30);
    // R1 dither shorter than the filter
    for (int k = 1; k <= 3; k++) begin
      enc_a = ~enc_a; repeat (k) @(negedge clk); enc_a = ~enc_a; repeat (30) @(negedge clk);
    end
    chk(qs.size() == 0 && qc.size() == 0, "R1 no pulse from dither", qs.size(), 0);
    // R7 pending slot: second queued, third dropped
    pulse_width = 8'd10; exp_pw = 10;
    step(1, 0, 2); step(1, 0, 2); step(1, 1, 60);
    chk(qs.size() == 0 && qc.size() == 0, "R7 queued event emitted", qs.size(), 0);
    step(-1, 0, 2); step(-1, 0, 60);
    pulse_width = 8'd3; exp_pw = 3;
    chk(!s_err && !c_err, "R8 flag clear before error", s_err, 0);
    // R8 both phases at once
    {enc_b, enc_a} = ~{enc_b, enc_a}; pos = (pos + 2) & 3;
    repeat (30) @(negedge clk);
    chk(s_err && c_err, "R8 flag set", s_err, 1);
    step(1, 0, 30); step(1, 0, 30);
    chk(s_err && c_err, "R8 flag sticky", c_err, 1);
    chk(qs.size() == 0 && qc.size() == 0, "R2 all expected pulses seen", qs.size(), 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule